// File: doc/BRIEF.md
# DC-Balanced Parallel Frame Encoder

This block sits in front of a serializer and turns one parallel word per clock into one fixed-length line frame. A mode input selects a 16-bit or 20-bit data path. Each frame gets four extra coding bits, so the frame is 20 or 24 bits long. Three kinds of frame share one layout: data frames, control frames and fill frames. A data frame can carry an extra flag bit. A control frame carries a shortened word. A fill frame keeps the link alive when no word is offered, and two reserved fill patterns are sent on request while the link is being brought up.

The coding field records the frame kind and whether the payload was complemented. The block keeps a running count of ones minus zeros over everything it has sent. It complements the payload whenever sending it unchanged would push that count further from zero. This keeps the line balanced for any user data. Two coding bits always differ from each other at the same frame position. That guaranteed transition lets a receiver find frame edges without separate sync words.

The output frame is registered, so a frame appears one clock after its inputs. In 16-bit mode the frame sits in the low 20 bits of the output bus.

Top module: `serial_frame_encoder`

## Requirements
- R1: In 20-bit mode the frame fills `frame_out[23:0]`, with the coding field in `[23:20]` and the payload in `[19:0]`. In 16-bit mode the coding field is in `[19:16]`, the payload is in `[15:0]`, and `[23:20]` read zero.
- R2: The coding field is laid out as follows. Bit 3 is 1 when the payload is complemented. Bit 2 is 1 for control and fill frames and 0 for data frames. Bit 1 is always the complement of bit 2. Bit 0 is the flag in data frames; in the other frames it is 1 for fill and 0 for control.
- R3: When `word_valid` is high and `ctrl_avail` and `train_req` are low, the next frame is a data frame. Its payload is the active width of `data_in`, complemented when coding bit 3 is set. Data bits above the active width are ignored.
- R4: In a data frame, coding bit 0 equals `flag_in` when `flag_en` is 1. It is 0 when `flag_en` is 0, whatever `flag_in` is.
- R5: When `word_valid` and `ctrl_avail` are high and `train_req` is low, the next frame is a control frame. Its uncomplemented payload holds the low 14 bits (16-bit mode) or 18 bits (20-bit mode) of `data_in`, and its top two payload bits are 0.
- R6: When `word_valid` and `train_req` are both low, the next frame is an idle fill frame. Its uncomplemented payload is alternating bits with ones in the odd positions (0xAAAA or 0xAAAAA).
- R7: `train_req` overrides `word_valid` and produces a fill frame carrying a training pattern. With `train_sel` 0 the upper half of the payload is ones and the lower half zeros (0xFF00 or 0xFFC00). With `train_sel` 1 the pattern is 0xCCCC or 0xCCCCC.
- R8: Let rd be the running disparity: ones minus zeros over all active frame bits sent since reset. Let D be the disparity of the frame sent uncomplemented. The payload is complemented exactly when rd >= 0 and D > 0, or when rd < 0 and D < 0.
- R9: The running disparity never leaves the range -24 to +24, and in a single mode it stays within plus or minus the frame length.
- R10: While reset is low the output is zero and the running disparity is cleared. The first frame after reset is encoded as if rd = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 selects the 20-bit data path, 0 the 16-bit path |
| flag_en | input | 1 | 1 carries `flag_in` in data frames |
| word_valid | input | 1 | A word is offered this cycle |
| ctrl_avail | input | 1 | The offered word is a control word |
| train_req | input | 1 | Send a training fill frame |
| train_sel | input | 1 | Selects which of the two training patterns is sent |
| flag_in | input | 1 | Flag bit sent with a data word |
| data_in | input | 20 | Parallel data or control word |
| frame_out | output | 24 | Encoded frame, one clock after its inputs |

## Verification
Every cycle, the embedded properties check three things. The running disparity stays bounded and never steps further from zero. Control, idle-fill and flag-suppressed data inputs produce the matching coding bits one clock later. A 16-bit frame leaves the top nibble clear. Some behaviour can only be shown by the bench's scenarios: the exact payload values, the training patterns, the choice of complement on a given input history, and the sequence of whole frames after reset. The bench rebuilds each expected frame from the requirements and sums the disparity of the frames it observes.

// File: rtl/serial_frame_encoder.sv
module serial_frame_encoder #(
  parameter int WIDE_W   = 20,
  parameter int NARROW_W = 16,
  parameter int CODE_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wide_mode,
  input  logic                       flag_en,
  input  logic                       word_valid,
  input  logic                       ctrl_avail,
  input  logic                       train_req,
  input  logic                       train_sel,
  input  logic                       flag_in,
  input  logic [WIDE_W-1:0]          data_in,
  output logic [WIDE_W+CODE_W-1:0]   frame_out
);
  localparam int FRAME_W = WIDE_W + CODE_W;
  localparam int RD_W    = $clog2(FRAME_W) + 3;
  localparam int PAD_W   = WIDE_W - NARROW_W;

  logic signed [RD_W-1:0] rd, d0, d1;
  logic [WIDE_W-1:0] act_mask, ctl_mask, idle_pat, trn_a_pat, trn_b_pat, pay, pay_o;
  logic special, c0, inv, armed;
  logic [CODE_W-1:0] code;
  logic [FRAME_W-1:0] frame_nxt;
  int w_act, n1;

  always_comb begin
    w_act = wide_mode ? WIDE_W : NARROW_W;
    for (int i = 0; i < WIDE_W; i++) begin
      act_mask[i]  = (i < w_act);
      ctl_mask[i]  = (i < w_act - 2);
      idle_pat[i]  = (i < w_act) && (i % 2 == 1);
      trn_b_pat[i] = (i < w_act) && (i % 4 >= 2);
      trn_a_pat[i] = (i < w_act) && (i >= w_act / 2);
    end
  end

  always_comb begin
    special = 1'b1;
    c0      = 1'b1;
    pay     = idle_pat;
    if (train_req) begin
      pay = train_sel ? trn_b_pat : trn_a_pat;
    end else if (word_valid && ctrl_avail) begin
      c0  = 1'b0;
      pay = data_in & ctl_mask;
    end else if (word_valid) begin
      special = 1'b0;
      c0      = flag_en & flag_in;
      pay     = data_in & act_mask;
    end
  end

  always_comb begin
    n1  = $countones(pay);
    d0  = RD_W'(2 * (n1 + 1 + int'(c0)) - (w_act + CODE_W));
    d1  = RD_W'(2 * (w_act - n1 + 2 + int'(c0)) - (w_act + CODE_W));
    inv = (rd >= 0) ? (d0 > 0) : (d0 < 0);
  end

  assign pay_o     = inv ? (pay ^ act_mask) : pay;
  assign code      = {inv, special, ~special, c0};
  assign frame_nxt = wide_mode ? {code, pay_o}
                               : {{PAD_W{1'b0}}, code, pay_o[NARROW_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_out <= '0;
      rd        <= '0;
      armed     <= 1'b0;
    end else begin
      frame_out <= frame_nxt;
      rd        <= rd + (inv ? d1 : d0);
      armed     <= 1'b1;
    end
  end

  p_rd_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd) <= FRAME_W) && (int'(rd) >= -FRAME_W));

  p_rd_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(rd) >= 0) |-> (rd <= $past(rd)));

  p_rd_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(rd) < 0) |-> (rd >= $past(rd)));

  p_ctrl_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(word_valid && ctrl_avail && !train_req)) |->
    (($past(wide_mode) ? frame_out[FRAME_W-2 -: 3] : frame_out[NARROW_W+CODE_W-2 -: 3]) == 3'b100));

  p_fill_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(!word_valid && !train_req)) |->
    (($past(wide_mode) ? frame_out[FRAME_W-2 -: 3] : frame_out[NARROW_W+CODE_W-2 -: 3]) == 3'b101));

  p_flag_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(word_valid && !ctrl_avail && !train_req && !flag_en)) |->
    (($past(wide_mode) ? frame_out[FRAME_W-2 -: 3] : frame_out[NARROW_W+CODE_W-2 -: 3]) == 3'b010));

  p_narrow_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(wide_mode)) |-> (frame_out[FRAME_W-1 -: PAD_W] == '0));
endmodule

// File: tb/sim_serial_frame_encoder.sv
module sim_serial_frame_encoder;
  localparam int CLK_P = 10;
  localparam int NV = 18;
  // {wide, flag_en, valid, ctrl, train_req, train_sel, flag, data[19:0]}
  localparam logic [26:0] VEC [NV] = '{
    {7'b1111001, 20'h12345}, {7'b1110000, 20'hFFFFF}, {7'b1110000, 20'h00000},
    {7'b1111000, 20'hABCDE}, {7'b1100000, 20'h55555}, {7'b1110100, 20'h13579},
    {7'b1100110, 20'h00000}, {7'b1010001, 20'h0F0F0}, {7'b0110001, 20'hF1234},
    {7'b0111000, 20'hFFFFF}, {7'b0000000, 20'h00000}, {7'b0010100, 20'h0000F},
    {7'b0000110, 20'h00000}, {7'b0110000, 20'h00000}, {7'b0110000, 20'h00000},
    {7'b1110000, 20'hFFFFF}, {7'b1110000, 20'h7FFFF}, {7'b1000000, 20'h00000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wide_mode = 1'b1, flag_en = 1'b0, word_valid = 1'b0, ctrl_avail = 1'b0;
  logic train_req = 1'b0, train_sel = 1'b0, flag_in = 1'b0;
  logic [19:0] data_in = '0;
  logic [23:0] frame_out;
  int checks = 0, errors = 0, m_rd = 0, obs_rd = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_frame_encoder u0 (.clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .flag_en(flag_en),
    .word_valid(word_valid), .ctrl_avail(ctrl_avail), .train_req(train_req), .train_sel(train_sel),
    .flag_in(flag_in), .data_in(data_in), .frame_out(frame_out));

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [26:0] v, input int rd_in, output logic [23:0] fr, output int rd_out);
    int w, ones, d0, d1;
    logic [19:0] p, m, po;
    logic sp, c0, inv;
    w = v[26] ? 20 : 16;
    m = v[26] ? 20'hFFFFF : 20'h0FFFF;
    if (v[22]) begin
      sp = 1'b1; c0 = 1'b1;
      p = v[21] ? (v[26] ? 20'hCCCCC : 20'h0CCCC) : (v[26] ? 20'hFFC00 : 20'h0FF00);
    end else if (v[24] && v[23]) begin
      sp = 1'b1; c0 = 1'b0; p = v[19:0] & (v[26] ? 20'h3FFFF : 20'h03FFF);
    end else if (v[24]) begin
      sp = 1'b0; c0 = v[25] & v[20]; p = v[19:0] & m;
    end else begin
      sp = 1'b1; c0 = 1'b1; p = v[26] ? 20'hAAAAA : 20'h0AAAA;
    end
    ones = $countones(p) + 1 + int'(c0);
    d0 = 2 * ones - (w + 4);
    d1 = 2 * ((w - $countones(p)) + 2 + int'(c0)) - (w + 4);
    inv = (rd_in >= 0) ? (d0 > 0) : (d0 < 0);
    po = inv ? (p ^ m) : p;
    fr = v[26] ? {inv, sp, ~sp, c0, po} : {4'h0, inv, sp, ~sp, c0, po[15:0]};
    rd_out = rd_in + (inv ? d1 : d0);
  endfunction

  task automatic apply(input logic [26:0] v);
    {wide_mode, flag_en, word_valid, ctrl_avail, train_req, train_sel, flag_in, data_in} = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [26:0] v);
    logic [23:0] exp;
    logic [3:0] cd;
    logic [19:0] pl;
    int nrd, len;
    string tag;
    model(v, m_rd, exp, nrd);
    m_rd = nrd;
    apply(v);
    if (v[22]) tag = "R7";
    else if (v[24] && v[23]) tag = "R5";
    else if (v[24] && !v[25] && v[20]) tag = "R4";
    else if (v[24]) tag = "R3";
    else tag = "R6";
    check(frame_out == exp, tag, frame_out, exp);
    cd = v[26] ? frame_out[23:20] : frame_out[19:16];
    pl = v[26] ? frame_out[19:0] : {4'h0, frame_out[15:0]};
    check(cd[2] != cd[1], "R2", {20'h0, cd}, {20'h0, cd[3], cd[2], ~cd[2], cd[0]});
    if (!v[26]) check(frame_out[23:20] == 4'h0, "R1", frame_out, {4'h0, frame_out[19:0]});
    if (v[24] && !v[23] && !v[22]) begin
      if (cd[3]) pl = pl ^ (v[26] ? 20'hFFFFF : 20'h0FFFF);
      check(pl == (v[19:0] & (v[26] ? 20'hFFFFF : 20'h0FFFF)), "R3", {4'h0, pl}, {4'h0, v[19:0]});
    end
    len = v[26] ? 24 : 20;
    obs_rd += 2 * $countones(frame_out) - len;
    check(obs_rd <= 24 && obs_rd >= -24, "R9", 24'(obs_rd), 24'd24);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(frame_out == 24'h0, "R10", frame_out, 24'h0);
    rst_n = 1'b1;
    m_rd = 0;
    obs_rd = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    do_reset();
    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    do_reset();
    apply({7'b1110000, 20'hFFFFF});
    check(frame_out == 24'hA00000, "R8", frame_out, 24'hA00000);
    apply({7'b1110000, 20'hFFFFF});
    check(frame_out == 24'h2FFFFF, "R8", frame_out, 24'h2FFFFF);

    do_reset();
    apply({7'b0110000, 20'h00000});
    check(frame_out == 24'h020000, "R10", frame_out, 24'h020000);
    apply({7'b0110000, 20'h00000});
    check(frame_out == 24'h0AFFFF, "R8", frame_out, 24'h0AFFFF);

    do_reset();
    for (int k = 0; k < 40; k++)
      run_vec({1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, k[0], 20'(k * 20'h0F3A1)});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule